// File: doc/BRIEF.md
# Asynchronous Bus Transfer Master

This block sits between a processor's control logic and a shared bus whose slaves answer through a request/acknowledge handshake. The slaves run independently of the processor clock. The processor presents one transfer at a time: a word write, a byte write, a word read, or a locked read that reserves the location for an immediate write-back. The master then drives the address, data and lane enables. It raises its sync strobe and waits for the slave's sync, which is synchronized into the processor clock domain. It then drops its strobe and waits for the slave to release.

The processor can be held in two ways. In interlocked mode it stalls for the whole transfer. In overlapped mode a read is launched and the processor keeps running. The processor raises a data-needed flag when it actually consumes the result, and it stalls only while that flag meets a read that has not yet finished. If a slave never answers, a cycle counter gives up, pulses a trap request and frees the bus.

Top module: `bus_xfer_master`

## Requirements
- R1: `req_kind` encodes the transfer: 0 word write, 1 byte write, 2 word read, 3 locked read. Kinds 0 and 1 drive `m_write` high and kinds 2 and 3 drive it low. Word transfers drive `m_byte_en` = 2'b11 and put `req_wdata` unchanged on `m_wdata`.
- R2: For a byte write, address bit 0 picks the lane: 0 gives `m_byte_en` = 2'b01 and 1 gives 2'b10. The low byte of `req_wdata` is copied onto both byte lanes of `m_wdata`.
- R3: A request is taken on a clock where `req_valid` and `req_ready` are both high, and `m_sync` rises on the next clock. `m_sync` falls on the clock after the slave sync has passed two synchronizer stages. No new request is taken until the synchronized slave sync is low again.
- R4: On a successful read, `rd_data` captures `s_rdata` on the clock where `m_sync` falls. It keeps that value through writes and timeouts until the next read completes.
- R5: After a locked read completes, `m_lock` stays high. While it is high, `req_ready` is low for every request except a write (kind 0 or 1) to the same word address (address bits above bit 0 equal). Completion of that write clears `m_lock`.
- R6: A write, or a read issued with `req_overlap` low, holds `cpu_stall` high from the clock after acceptance until the master is idle again.
- R7: A read issued with `req_overlap` high leaves `cpu_stall` low, except while `data_need` is high and the read data has not yet been captured.
- R8: If the slave sync is not seen within `TIMEOUT_CYC` clocks of waiting, the master pulses `trap_req` for one clock, drops `m_sync`, clears `m_lock` and returns to idle.
- R9: During and right after reset, `m_sync`, `cpu_stall`, `trap_req`, `m_lock` and `rd_data` are zero, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor presents a transfer |
| req_kind | input | 2 | Transfer kind (see R1) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data |
| req_overlap | input | 1 | Let the processor run during this read |
| req_ready | output | 1 | Request may be taken this clock |
| data_need | input | 1 | Processor needs the pending read data now |
| cpu_stall | output | 1 | Stop the processor clock |
| rd_data | output | 16 | Last captured read data |
| trap_req | output | 1 | One-clock bus timeout trap |
| m_sync | output | 1 | Master sync strobe |
| m_write | output | 1 | Transfer direction, high for write |
| m_lock | output | 1 | Location reserved for write-back |
| m_addr | output | ADDR_W | Bus address |
| m_wdata | output | 16 | Bus write data |
| m_byte_en | output | 2 | Byte lane enables |
| s_sync | input | 1 | Slave sync, asynchronous |
| s_rdata | input | 16 | Slave read data, stable while slave sync is high |

## Verification
The hardest situation to reach is the locked window. A locked read must have finished, and the bench must then present, at the idle ports, requests that differ only in kind or in word address while the reservation holds. The bench completes a locked read and parks. It then changes `req_kind` and `req_addr` without raising `req_valid` and reads `req_ready` for each combination. Only after that does it issue the matching write-back. The overlapped stall is reached by raising `data_need` a few clocks into a deliberately slow slave answer.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
    localparam int WORD_W = 16;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        XK_WR_WORD  = 2'd0,
        XK_WR_BYTE  = 2'd1,
        XK_RD_WORD  = 2'd2,
        XK_RD_LOCK  = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_WAIT    = 2'd1,
        PH_RELEASE = 2'd2
    } phase_e;

    typedef struct packed {
        logic              write;
        logic [LANES-1:0]  ben;
        logic [WORD_W-1:0] wdata;
    } lane_t;

    function automatic logic kind_is_write(xfer_kind_e k);
        return !k[1];
    endfunction
endpackage

// File: rtl/bxm_sync.sv
module bxm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bxm_timer.sv
module bxm_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)   cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bxm_lane.sv
module bxm_lane
    import bxm_pkg::*;
(
    input  xfer_kind_e        kind,
    input  logic              addr_lsb,
    input  logic [WORD_W-1:0] wdata,
    output lane_t             lane
);
    always_comb begin
        lane.write = kind_is_write(kind);
        if (kind == XK_WR_BYTE) begin
            lane.ben   = addr_lsb ? 2'b10 : 2'b01;
            lane.wdata = {wdata[7:0], wdata[7:0]};
        end else begin
            lane.ben   = '1;
            lane.wdata = wdata;
        end
    end
endmodule

// File: rtl/bus_xfer_master.sv
module bus_xfer_master
    import bxm_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              req_overlap,
    output logic              req_ready,
    input  logic              data_need,
    output logic              cpu_stall,
    output logic [15:0]       rd_data,
    output logic              trap_req,
    output logic              m_sync,
    output logic              m_write,
    output logic              m_lock,
    output logic [ADDR_W-1:0] m_addr,
    output logic [15:0]       m_wdata,
    output logic [1:0]        m_byte_en,
    input  logic              s_sync,
    input  logic [15:0]       s_rdata
);
    xfer_kind_e        kind_in, kind_q;
    phase_e            phase;
    lane_t             lane_d, lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       rdata_q;
    logic              sync_q, locked_q, ovr_q, rdp_q, trap_q;
    logic              seen, expired, same_word, grant_ok, accept;

    assign kind_in = xfer_kind_e'(req_kind);

    bxm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(s_sync), .q(seen)
    );

    bxm_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(phase == PH_WAIT), .expired(expired)
    );

    bxm_lane u_lane (
        .kind(kind_in), .addr_lsb(req_addr[0]), .wdata(req_wdata), .lane(lane_d)
    );

    assign same_word = (req_addr[ADDR_W-1:1] == addr_q[ADDR_W-1:1]);
    assign grant_ok  = (phase == PH_IDLE) &&
                       (!locked_q || (kind_is_write(kind_in) && same_word));
    assign accept    = req_valid && grant_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            kind_q   <= XK_WR_WORD;
            lane_q   <= '0;
            addr_q   <= '0;
            rdata_q  <= '0;
            sync_q   <= 1'b0;
            locked_q <= 1'b0;
            ovr_q    <= 1'b0;
            rdp_q    <= 1'b0;
            trap_q   <= 1'b0;
        end else begin
            trap_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase  <= PH_WAIT;
                        sync_q <= 1'b1;
                        kind_q <= kind_in;
                        lane_q <= lane_d;
                        addr_q <= req_addr;
                        ovr_q  <= req_overlap && !kind_is_write(kind_in);
                        rdp_q  <= req_overlap && !kind_is_write(kind_in);
                        if (kind_in == XK_RD_LOCK) locked_q <= 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (seen) begin
                        phase  <= PH_RELEASE;
                        sync_q <= 1'b0;
                        rdp_q  <= 1'b0;
                        if (kind_is_write(kind_q)) locked_q <= 1'b0;
                        else                       rdata_q  <= s_rdata;
                    end else if (expired) begin
                        phase    <= PH_IDLE;
                        sync_q   <= 1'b0;
                        rdp_q    <= 1'b0;
                        locked_q <= 1'b0;
                        trap_q   <= 1'b1;
                    end
                end
                PH_RELEASE: begin
                    if (!seen) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = grant_ok;
    assign cpu_stall = ((phase != PH_IDLE) && !ovr_q) || (data_need && rdp_q);
    assign rd_data   = rdata_q;
    assign trap_req  = trap_q;
    assign m_sync    = sync_q;
    assign m_write   = lane_q.write;
    assign m_lock    = locked_q;
    assign m_addr    = addr_q;
    assign m_wdata   = lane_q.wdata;
    assign m_byte_en = lane_q.ben;
endmodule

// File: rtl/bxm_checker.sv
module bxm_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              cpu_stall,
    input logic [15:0]       rd_data,
    input logic              trap_req,
    input logic              m_sync,
    input logic              m_write,
    input logic              m_lock,
    input logic [ADDR_W-1:0] m_addr,
    input logic [1:0]        m_byte_en
);
    AST_SYNC_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(m_sync) |-> $past(req_valid && req_ready)); // R3

    AST_TRAP_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> !trap_req); // R8

    AST_TRAP_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> !m_sync); // R8

    AST_LOCK_ONLY_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (m_lock && req_valid && req_ready) |->
            (!req_kind[1] && (req_addr[ADDR_W-1:1] == m_addr[ADDR_W-1:1]))); // R5

    AST_RDATA_ON_READ_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> ($fell(m_sync) && !m_write)); // R4

    AST_BYTE_LANE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (m_sync && m_write && (m_byte_en != 2'b11)) |->
            (m_byte_en == (m_addr[0] ? 2'b10 : 2'b01))); // R2

    AST_WRITE_HOLDS_CPU: assert property (@(posedge clk) disable iff (rst)
        (m_sync && m_write) |-> cpu_stall); // R6
endmodule

bind bus_xfer_master bxm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_ready(req_ready), .cpu_stall(cpu_stall),
    .rd_data(rd_data), .trap_req(trap_req), .m_sync(m_sync),
    .m_write(m_write), .m_lock(m_lock), .m_addr(m_addr), .m_byte_en(m_byte_en)
);

// File: tb/sim_bus_xfer_master.sv
`timescale 1ns/1ps
module sim_bus_xfer_master;
    localparam int AW = 16;
    localparam int TO = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_overlap = 1'b0;
    logic          data_need = 1'b0;
    logic          s_sync = 1'b0;
    logic [15:0]   s_rdata = '0;
    logic          req_ready, cpu_stall, trap_req, m_sync, m_write, m_lock;
    logic [15:0]   rd_data, m_wdata;
    logic [AW-1:0] m_addr;
    logic [1:0]    m_byte_en;

    always #10 clk = ~clk;

    bus_xfer_master #(.ADDR_W(AW), .TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_overlap(req_overlap),
        .req_ready(req_ready), .data_need(data_need), .cpu_stall(cpu_stall),
        .rd_data(rd_data), .trap_req(trap_req), .m_sync(m_sync),
        .m_write(m_write), .m_lock(m_lock), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_byte_en(m_byte_en), .s_sync(s_sync), .s_rdata(s_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_trap = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int          r_ph;      // 0 idle, 1 waiting for slave, 2 waiting for release
    int          r_cnt;
    bit          r_s1, r_s2;
    bit          r_sync, r_lock, r_ovr, r_rdp, r_trap, r_wr;
    logic [15:0] r_rdata;
    logic [AW-1:0] r_addr;

    function automatic bit ref_ready();
        if (r_ph != 0) return 0;
        if (!r_lock) return 1;
        return (req_kind < 2) && (req_addr[AW-1:1] == r_addr[AW-1:1]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            r_ph = 0; r_cnt = 0; r_s1 = 0; r_s2 = 0; r_sync = 0; r_lock = 0;
            r_ovr = 0; r_rdp = 0; r_trap = 0; r_wr = 0; r_rdata = 0; r_addr = 0;
        end else begin
            bit acc;
            acc = req_valid && ref_ready();
            r_trap = 0;
            if (r_ph == 0) begin
                if (acc) begin
                    r_ph = 1; r_cnt = 0; r_sync = 1; r_addr = req_addr;
                    r_wr = (req_kind < 2);
                    r_ovr = req_overlap && !r_wr;
                    r_rdp = r_ovr;
                    if (req_kind == 2'd3) r_lock = 1;
                end
            end else if (r_ph == 1) begin
                if (r_s2) begin
                    r_ph = 2; r_sync = 0; r_rdp = 0;
                    if (r_wr) r_lock = 0; else r_rdata = s_rdata;
                end else if (r_cnt == TO - 1) begin
                    r_ph = 0; r_sync = 0; r_rdp = 0; r_lock = 0; r_trap = 1;
                end else r_cnt++;
            end else begin
                if (!r_s2) r_ph = 0;
            end
            r_s2 = r_s1;
            r_s1 = s_sync;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R3 m_sync", m_sync, r_sync);
            chk("R3 req_ready", req_ready, ref_ready());
            chk("R6/R7 cpu_stall", cpu_stall, ((r_ph != 0) && !r_ovr) || (data_need && r_rdp));
            chk("R4 rd_data", rd_data, r_rdata);
            chk("R8 trap_req", trap_req, r_trap);
            chk("R5 m_lock", m_lock, r_lock);
            if (trap_req) n_trap++;
        end
    end

    // ---------------- slave ----------------
    logic [15:0] mem [16];
    int          resp_delay = 2;
    int          scnt = 0;
    logic [1:0]  exp_ben = 2'b11;
    logic [15:0] exp_wd = '0;
    bit          exp_wr = 0;

    always @(posedge clk) begin
        #1;
        if (rst) begin
            s_sync = 0; scnt = 0;
            for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i);
        end else if (m_sync && !s_sync) begin
            if (resp_delay >= 0) begin
                if (scnt == resp_delay) begin
                    chk("R1 m_write", m_write, exp_wr);
                    if (m_write) begin
                        chk("R1/R2 m_byte_en", m_byte_en, exp_ben);
                        chk("R1/R2 m_wdata", m_wdata, exp_wd);
                        if (m_byte_en[0]) mem[m_addr[4:1]][7:0]  = m_wdata[7:0];
                        if (m_byte_en[1]) mem[m_addr[4:1]][15:8] = m_wdata[15:8];
                    end else begin
                        s_rdata = mem[m_addr[4:1]];
                    end
                    s_sync = 1; scnt = 0;
                end else scnt++;
            end
        end else if (!m_sync) begin
            scnt = 0;
            if (s_sync) s_sync = 0;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [15:0] d,
                         input logic ov);
        @(posedge clk); #2;
        req_valid = 1; req_kind = k; req_addr = a; req_wdata = d; req_overlap = ov;
        exp_wr = (k < 2);
        if (k == 2'd1) begin
            exp_ben = a[0] ? 2'b10 : 2'b01;
            exp_wd  = {d[7:0], d[7:0]};
        end else begin
            exp_ben = 2'b11;
            exp_wd  = d;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #2;
        req_valid = 0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (m_sync || s_sync) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic probe_ready(input logic [1:0] k, input logic [15:0] a, input bit exp,
                               input string tag);
        @(posedge clk); #2;
        req_kind = k; req_addr = a;
        @(negedge clk);
        chk(tag, req_ready, exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9: reset state
        chk("R9 m_sync", m_sync, 0);
        chk("R9 cpu_stall", cpu_stall, 0);
        chk("R9 trap_req", trap_req, 0);
        chk("R9 m_lock", m_lock, 0);
        chk("R9 rd_data", rd_data, 0);
        chk("R9 req_ready", req_ready, 1);
        @(posedge clk); #2 rst = 0;

        // R1: word write, interlocked
        resp_delay = 2;
        issue(2'd0, 16'h0004, 16'hA5A5, 0);
        @(negedge clk);
        chk("R6 stall during write", cpu_stall, 1);
        wait_idle();

        // R2: byte writes, both lanes
        issue(2'd1, 16'h0006, 16'h113C, 0); wait_idle();
        issue(2'd1, 16'h0007, 16'h22C3, 0); wait_idle();

        // R4: interlocked word read of the merged word
        resp_delay = 5;
        issue(2'd2, 16'h0006, 16'h0000, 0); wait_idle();
        chk("R4 read value", rd_data, 16'hC33C);

        // R4: a write leaves rd_data alone
        resp_delay = 1;
        issue(2'd0, 16'h0008, 16'h7777, 1); wait_idle();
        chk("R4 held over write", rd_data, 16'hC33C);

        // R7: overlapped read, processor runs until it needs data
        resp_delay = 8;
        issue(2'd2, 16'h0004, 16'h0000, 1);
        repeat (2) @(negedge clk);
        chk("R7 no stall while running", cpu_stall, 0);
        @(posedge clk); #2 data_need = 1;
        @(negedge clk);
        chk("R7 stall on data need", cpu_stall, 1);
        wait_idle();
        chk("R7 released after data", cpu_stall, 0);
        chk("R4 overlapped value", rd_data, 16'hA5A5);
        @(posedge clk); #2 data_need = 0;

        // R5: locked read and its write-back
        resp_delay = 1;
        issue(2'd3, 16'h000A, 16'h0000, 0); wait_idle();
        chk("R5 lock held", m_lock, 1);
        chk("R4 locked read value", rd_data, 16'h1005);
        probe_ready(2'd2, 16'h000A, 0, "R5 read refused");
        probe_ready(2'd0, 16'h000C, 0, "R5 other word refused");
        probe_ready(2'd1, 16'h000B, 1, "R5 byte writeback allowed");
        probe_ready(2'd0, 16'h000A, 1, "R5 word writeback allowed");
        issue(2'd0, 16'h000A, 16'h5A5A, 0); wait_idle();
        chk("R5 lock cleared", m_lock, 0);
        probe_ready(2'd2, 16'h0002, 1, "R5 read allowed again");

        // R8: timeout on a read, then on a locked read
        resp_delay = -1;
        issue(2'd2, 16'h0002, 16'h0000, 0); wait_idle();
        chk("R8 one trap", n_trap, 1);
        chk("R8 rd_data kept", rd_data, 16'h1005);
        issue(2'd3, 16'h000E, 16'h0000, 0); wait_idle();
        chk("R8 second trap", n_trap, 2);
        chk("R8 lock dropped", m_lock, 0);

        // R1: write-back landed in the slave
        resp_delay = 0;
        issue(2'd2, 16'h000A, 16'h0000, 0); wait_idle();
        chk("R1 write-back visible", rd_data, 16'h5A5A);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule